// File: doc/BRIEF.md
# ROM chip-select decoder with size-selectable bank bits

This block sits between an upstream address generator and a bank of four ROM slots. Each slot holds one ROM, or in a graphics setup two ROMs in parallel. The block takes a linear word address and a static setting that gives the size of the largest installed ROM: 8, 16 or 32 Mbit. It picks the two address bits just above that ROM's internal range and decodes them into four active-low output enables. Exactly one enable is low at a time. The lower address bits go on to the ROMs unchanged.

The decode pair moves up one bit position each time the configured size doubles, so one decoder serves all three sizes. An 8 Mbit part is 512K 16-bit words with 19 internal word address bits, so the 8 Mbit setting decodes word address bits 19 and 20. A global enable turns all four slots off.

A 4 Mbit part may sit only in the last populated slot. It needs no special logic. The slot choice never looks at address bits below the decode pair, and the smaller part leaves its top address pin unconnected, so its contents repeat in both halves of the slot window.

Top module: `rom_cs_decoder`

## Requirements
- R1: The setting `size_cfg` is encoded as 0 for 8 Mbit, 1 for 16 Mbit and 2 for 32 Mbit. Code 3 is decoded exactly like code 0 (8 Mbit).
- R2: While `en` is 1, exactly one bit of `oe_n[3:0]` is 0.
- R3: With the 8 Mbit setting, the slot index is `addr[20:19]` (bit 19 is the LSB of the index), and `oe_n[index]` is 0.
- R4: With the 16 Mbit setting, the slot index is `addr[21:20]`.
- R5: With the 32 Mbit setting, the slot index is `addr[22:21]`.
- R6: While `en` is 0, `oe_n` is 4'hF whatever the address and setting. This includes the bench's reset period.
- R7: `rom_addr[18:0]` equals `addr[18:0]` for every setting.
- R8: Bits of `rom_addr` at or above the ROM's internal width are 0, and bits below it follow `addr`:
  - 8 Mbit: `rom_addr[20:19]` is 0.
  - 16 Mbit: `rom_addr[19]` equals `addr[19]` and `rom_addr[20]` is 0.
  - 32 Mbit: `rom_addr[20:0]` equals `addr[20:0]`.
- R9: The slot choice does not depend on address bits outside the decode pair. For example, under the 8 Mbit setting, `addr[22:21]` and `addr[18]` do not change `oe_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en | input | 1 | Global enable; 0 forces all slot enables high |
| size_cfg | input | 2 | Static size of the largest ROM: 0=8M, 1=16M, 2=32M, 3=8M |
| addr | input | 23 | Linear word address from the upstream generator |
| oe_n | output | 4 | Active-low output enables, one per slot |
| rom_addr | output | 21 | Word address presented to the ROMs |

## Verification
The assertions treat the block as purely combinational. They assume that `size_cfg` and `addr` are settled whenever the outputs are compared, and that `size_cfg` is a static strap that can take any of its four codes. The bench meets these assumptions in three ways. It changes all inputs together on one clock edge and compares on the opposite edge. It holds `en` low during reset. It also drives the unused code 3, so the fallback decode is covered rather than assumed away.

// File: rtl/rom_cs_pkg.sv
// Package: shared type for the ROM chip-select decoder.
// Assumes: size codes above the last named one fall back to the smallest size.
package rom_cs_pkg;

    // Named ROM size codes as seen on the configuration strap.
    typedef enum logic [1:0] {
        SZ_8M  = 2'd0,
        SZ_16M = 2'd1,
        SZ_32M = 2'd2
    } rom_size_e;

endpackage

// File: rtl/rom_size_shift.sv
// rom_size_shift: turns the size strap into a bit shift.
// The shift is how far the decode pair moves above the smallest ROM's range.
// Assumes: codes 0..NUM_SIZES-1 are valid; any other code maps to shift 0.
module rom_size_shift #(
    parameter int CFG_W     = 2,
    parameter int NUM_SIZES = 3,
    parameter int SH_W      = 2
) (
    input  logic [CFG_W-1:0] size_cfg,
    output logic [SH_W-1:0]  shift
);

    // Match the strap against each supported size; unmatched codes keep 0.
    always_comb begin
        shift = '0;
        for (int k = 0; k < NUM_SIZES; k++) begin
            if (size_cfg == CFG_W'(k)) begin
                shift = SH_W'(k);
            end
        end
    end

endmodule

// File: rtl/bank_pair_pick.sv
// bank_pair_pick: picks the SEL_W address bits that select a slot.
// Assumes: hi_addr starts at the first bit above the smallest ROM's range,
// and shift is always below NUM_SIZES.
module bank_pair_pick #(
    parameter int NUM_SIZES = 3,
    parameter int SEL_W     = 2,
    parameter int SH_W      = 2,
    localparam int HI_W     = NUM_SIZES - 1 + SEL_W
) (
    input  logic [HI_W-1:0]  hi_addr,
    input  logic [SH_W-1:0]  shift,
    output logic [SEL_W-1:0] pair
);

    logic [SEL_W-1:0] cand [NUM_SIZES];

    // One candidate bit window per supported size.
    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_cand
        assign cand[k] = hi_addr[k +: SEL_W];
    end

    // Steer the window that matches the current shift.
    always_comb begin
        pair = '0;
        for (int k = 0; k < NUM_SIZES; k++) begin
            if (shift == SH_W'(k)) begin
                pair = cand[k];
            end
        end
    end

endmodule

// File: rtl/slot_decoder.sv
// slot_decoder: SEL_W-to-2^SEL_W decoder with active-low outputs and a gate.
// Assumes: nothing about pair; every value selects exactly one output.
module slot_decoder #(
    parameter int SEL_W   = 2,
    localparam int NUM_OUT = 1 << SEL_W
) (
    input  logic               en,
    input  logic [SEL_W-1:0]   pair,
    output logic [NUM_OUT-1:0] oe_n
);

    // Each output goes low only when enabled and addressed.
    for (genvar j = 0; j < NUM_OUT; j++) begin : g_out
        assign oe_n[j] = ~(en & (pair == SEL_W'(j)));
    end

endmodule

// File: rtl/rom_addr_pass.sv
// rom_addr_pass: forwards the address bits inside the configured ROM range.
// Bits above that range are forced to zero.
// Assumes: shift is below NUM_SIZES.
module rom_addr_pass #(
    parameter int BASE_AW   = 19,
    parameter int NUM_SIZES = 3,
    parameter int SH_W      = 2,
    localparam int MAX_AW   = BASE_AW + NUM_SIZES - 1
) (
    input  logic [MAX_AW-1:0] lo_addr,
    input  logic [SH_W-1:0]   shift,
    output logic [MAX_AW-1:0] rom_addr
);

    // Bits inside the smallest ROM always pass; larger ones are gated by size.
    for (genvar i = 0; i < MAX_AW; i++) begin : g_bit
        if (i < BASE_AW) begin : g_fixed
            assign rom_addr[i] = lo_addr[i];
        end else begin : g_gated
            assign rom_addr[i] = lo_addr[i] & (int'(shift) > (i - BASE_AW));
        end
    end

endmodule

// File: rtl/rom_cs_decoder.sv
// rom_cs_decoder: top level of the size-selectable ROM slot decoder.
// It is purely combinational: strap -> shift, then shift picks the decode
// pair, then the pair drives the enables, and the shift also masks the
// address.
// Assumes: size_cfg is static; addr is a word address.
module rom_cs_decoder #(
    parameter int BASE_AW   = 19,
    parameter int NUM_SIZES = 3,
    parameter int SEL_W     = 2,
    parameter int CFG_W     = 2,
    localparam int MAX_AW   = BASE_AW + NUM_SIZES - 1,
    localparam int ADDR_W   = MAX_AW + SEL_W,
    localparam int NUM_SLOT = 1 << SEL_W,
    localparam int SH_W     = (NUM_SIZES > 1) ? $clog2(NUM_SIZES) : 1
) (
    input  logic                en,
    input  logic [CFG_W-1:0]    size_cfg,
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_SLOT-1:0] oe_n,
    output logic [MAX_AW-1:0]   rom_addr
);

    logic [SH_W-1:0]  shift;
    logic [SEL_W-1:0] pair;

    rom_size_shift #(
        .CFG_W(CFG_W), .NUM_SIZES(NUM_SIZES), .SH_W(SH_W)
    ) u_shift (
        .size_cfg(size_cfg),
        .shift   (shift)
    );

    bank_pair_pick #(
        .NUM_SIZES(NUM_SIZES), .SEL_W(SEL_W), .SH_W(SH_W)
    ) u_pick (
        .hi_addr(addr[ADDR_W-1:BASE_AW]),
        .shift  (shift),
        .pair   (pair)
    );

    slot_decoder #(
        .SEL_W(SEL_W)
    ) u_dec (
        .en  (en),
        .pair(pair),
        .oe_n(oe_n)
    );

    rom_addr_pass #(
        .BASE_AW(BASE_AW), .NUM_SIZES(NUM_SIZES), .SH_W(SH_W)
    ) u_pass (
        .lo_addr (addr[MAX_AW-1:0]),
        .shift   (shift),
        .rom_addr(rom_addr)
    );

endmodule

// File: rtl/rom_cs_decoder_chk.sv
// rom_cs_decoder_chk: port-level checks for rom_cs_decoder.
// Assumes: the default of three sizes (shift 0, 1, 2) and settled inputs.
module rom_cs_decoder_chk #(
    parameter int BASE_AW = 19,
    parameter int SEL_W   = 2,
    parameter int CFG_W   = 2,
    parameter int MAX_AW  = 21,
    parameter int ADDR_W  = 23,
    parameter int NSLOT   = 4
) (
    input logic              en,
    input logic [CFG_W-1:0]  size_cfg,
    input logic [ADDR_W-1:0] addr,
    input logic [NSLOT-1:0]  oe_n,
    input logic [MAX_AW-1:0] rom_addr
);

    // Check the enables and the address against the strap and the address.
    always_comb begin
        if (en) begin
            a_r2_one_slot: assert ($countones(~oe_n) == 1);
        end else begin
            a_r6_all_idle: assert (oe_n == '1);
        end
        if (en && size_cfg == CFG_W'(0)) begin
            a_r3_pair_8m: assert (oe_n[addr[BASE_AW +: SEL_W]] == 1'b0);
        end
        if (en && size_cfg == CFG_W'(1)) begin
            a_r4_pair_16m: assert (oe_n[addr[BASE_AW + 1 +: SEL_W]] == 1'b0);
        end
        if (en && size_cfg == CFG_W'(2)) begin
            a_r5_pair_32m: assert (oe_n[addr[BASE_AW + 2 +: SEL_W]] == 1'b0);
        end
        if (en && size_cfg == CFG_W'(3)) begin
            a_r1_code3_as_8m: assert (oe_n[addr[BASE_AW +: SEL_W]] == 1'b0);
        end
        a_r7_low_bits: assert (rom_addr[BASE_AW-1:0] == addr[BASE_AW-1:0]);
        if (size_cfg == CFG_W'(2)) begin
            a_r8_full_pass: assert (rom_addr == addr[MAX_AW-1:0]);
        end else if (size_cfg == CFG_W'(1)) begin
            a_r8_mid_pass: assert (rom_addr[MAX_AW-1:BASE_AW] == {1'b0, addr[BASE_AW]});
        end else begin
            a_r8_top_zero: assert (rom_addr[MAX_AW-1:BASE_AW] == '0);
        end
    end

endmodule

bind rom_cs_decoder rom_cs_decoder_chk #(
    .BASE_AW(BASE_AW), .SEL_W(SEL_W), .CFG_W(CFG_W),
    .MAX_AW(MAX_AW), .ADDR_W(ADDR_W), .NSLOT(NUM_SLOT)
) u_chk (
    .en(en), .size_cfg(size_cfg), .addr(addr), .oe_n(oe_n), .rom_addr(rom_addr)
);

// File: tb/rom_cs_decoder_bench.sv
// rom_cs_decoder_bench: scoreboard bench. The driver queues expected outputs
// and the monitor compares them on the falling edge.
module rom_cs_decoder_bench;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [1:0]  size_cfg = 2'd0;
    logic [22:0] addr = '0;
    logic [3:0]  oe_n;
    logic [20:0] rom_addr;

    int checks = 0;
    int errors = 0;
    logic [3:0]  q_oe[$];
    logic [20:0] q_ra[$];
    string       q_tag[$];

    // 200 MHz clock.
    always #2.5 clk = ~clk;

    rom_cs_decoder u_rom_cs_decoder (
        .en(en), .size_cfg(size_cfg), .addr(addr), .oe_n(oe_n), .rom_addr(rom_addr)
    );

    // Reference model of the requirements: shift, slot index and address mask.
    function automatic int size_shift(input logic [1:0] s);
        return (s == 2'd1) ? 1 : (s == 2'd2) ? 2 : 0;
    endfunction

    // Apply one input set at the rising edge and queue the expected outputs.
    task automatic drive(input logic e, input logic [1:0] s, input logic [22:0] a,
                         input string tag);
        int sh;
        int slot;
        logic [3:0] exp_oe;
        logic [22:0] mask;
        @(posedge clk);
        en = e; size_cfg = s; addr = a;
        sh = size_shift(s);
        slot = int'((a >> (19 + sh)) & 23'h3);
        exp_oe = e ? ~(4'b0001 << slot) : 4'hF;
        mask = (23'h1 << (19 + sh)) - 23'h1;
        q_oe.push_back(exp_oe);
        q_ra.push_back(21'(a & mask));
        q_tag.push_back(tag);
    endtask

    // Monitor: compare one queued item per falling edge.
    always @(negedge clk) begin
        if (rst_n && q_oe.size() > 0) begin
            logic [3:0]  eo;
            logic [20:0] er;
            string t;
            eo = q_oe.pop_front();
            er = q_ra.pop_front();
            t = q_tag.pop_front();
            checks++;
            if (oe_n !== eo) begin
                errors++;
                $display("FAIL %s oe_n: actual %h expected %h", t, oe_n, eo);
            end
            checks++;
            if (rom_addr !== er) begin
                errors++;
                $display("FAIL %s rom_addr: actual %h expected %h", t, rom_addr, er);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [22:0] lfsr;
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        // R6 reset state: en low at reset, so every slot must be idle.
        drive(1'b0, 2'd0, 23'h0, "R6 reset");
        // R3 R4 R5 R1 R2: walk every slot for every strap code.
        for (int s = 0; s < 4; s++) begin
            for (int j = 0; j < 4; j++) begin
                int sh;
                string tg;
                sh = size_shift(2'(s));
                tg = (s == 0) ? "R3 R2" : (s == 1) ? "R4 R2" : (s == 2) ? "R5 R2" : "R1 R2";
                drive(1'b1, 2'(s), (23'(j) << (19 + sh)) | 23'h0155AA, tg);
            end
        end
        // R6: disabled with varied addresses and sizes.
        drive(1'b0, 2'd1, 23'h7FFFFF, "R6");
        drive(1'b0, 2'd2, 23'h600000, "R6");
        drive(1'b0, 2'd3, 23'h180000, "R6");
        // R7 R8: all-ones address for each size shows the masking.
        for (int s = 0; s < 4; s++) begin
            drive(1'b1, 2'(s), 23'h7FFFFF, "R7 R8");
        end
        drive(1'b1, 2'd1, 23'h080000, "R8 16M bit19");
        // R9: bits outside the pair do not move the slot (8M setting).
        drive(1'b1, 2'd0, 23'h600000, "R9 high bits");
        drive(1'b1, 2'd0, 23'h640000, "R9 bit18");
        drive(1'b1, 2'd0, 23'h0C0000, "R9 bit18 slot1");
        drive(1'b1, 2'd1, 23'h490000, "R9 16M");
        // R2 R7: pseudo-random sweep.
        lfsr = 23'h2A5C13;
        for (int n = 0; n < 120; n++) begin
            lfsr = {lfsr[21:0], lfsr[22] ^ lfsr[17]};
            drive(lfsr[3] | lfsr[9], lfsr[6:5], lfsr, "R2 R7 sweep");
        end
        while (q_oe.size() > 0) @(posedge clk);
        @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule